// File: doc/BRIEF.md
# Timer Compare Reference Output

This block turns one timer channel into an output-compare unit. Each clock it compares the running counter value with a compare value. A 3-bit mode code then decides the next level of a registered reference output. The modes are: hold the level, set, clear or toggle on an equal count, force a fixed level, or derive a pulse-width level from a magnitude compare.

A gated external clear overrides every mode and drives the reference low. Once triggered, the clear stays in force until the next update-event strobe, even if the external clear input drops before then. The counter itself is built elsewhere, as are polarity, dead time and the pin stage. The reference level feeds those stages.

Top module: `oc_ref_channel`

## Requirements
- R1: While `rst_n` is low, `ref_out` is 0. After `rst_n` rises, the block ignores its inputs for two clock edges, and the first edge that acts on them is the third.
- R2: With `oc_mode` = 0 and no clear active, `ref_out` keeps its level on every edge, including edges where `cnt_val` equals `cmp_val`.
- R3: With `oc_mode` = 1, `ref_out` becomes 1 on the edge after `cnt_val` equals `cmp_val`. It keeps its level when the two differ.
- R4: With `oc_mode` = 2, `ref_out` becomes 0 on the edge after `cnt_val` equals `cmp_val`. It keeps its level when the two differ.
- R5: With `oc_mode` = 3, `ref_out` inverts on every edge at which `cnt_val` equals `cmp_val`. It keeps its level otherwise.
- R6: `oc_mode` = 4 drives `ref_out` to 0 and `oc_mode` = 5 drives it to 1 after the next edge, whatever the compare result.
- R7: With `oc_mode` = 6, `ref_out` after an edge is 1 when `cnt_val` < `cmp_val` (unsigned) and 0 otherwise. This holds whether the counter rises or falls.
- R8: With `oc_mode` = 7, `ref_out` after an edge is 0 when `cnt_val` < `cmp_val` and 1 otherwise.
- R9: An edge with `clr_en` = 1 and `ext_clr` = 1 makes `ref_out` 0 after that edge, in every mode.
- R10: After a clear edge as in R9, `ref_out` stays 0 until an edge where `upd_evt` = 1 and no new clear occurs. The mode rules act again from the edge after that one.
- R11: With `clr_en` = 0, `ext_clr` has no effect on `ref_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Compare value |
| oc_mode | input | 3 | Output mode code (0..7) |
| clr_en | input | 1 | Enables the external clear |
| ext_clr | input | 1 | External clear request, synchronous to clk |
| upd_evt | input | 1 | Update-event strobe, one cycle wide |
| ref_out | output | 1 | Registered reference level |

## Verification
The properties assume that `cnt_val`, `cmp_val`, `oc_mode` and the clear controls are synchronous to `clk` and steady around each rising edge. They also assume that the mode code holds still for the edge being judged. The bench drives every input one time unit after a rising edge and reads `ref_out` one time unit after the next edge, so each input set is seen by exactly one edge. Counter sweeps run both upward and downward through the compare value, because the pulse-width rules must not depend on the direction of travel.

// File: rtl/oc_chan_pkg.sv
package oc_chan_pkg;

  typedef enum logic [2:0] {
    OCM_FREEZE = 3'd0,
    OCM_SET    = 3'd1,
    OCM_CLR    = 3'd2,
    OCM_TGL    = 3'd3,
    OCM_LO     = 3'd4,
    OCM_HI     = 3'd5,
    OCM_PWM_A  = 3'd6,
    OCM_PWM_B  = 3'd7
  } oc_mode_e;

  localparam int unsigned OC_MODE_W = 3;

endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/oc_cmp_unit.sv
module oc_cmp_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             is_equal,
  output logic             is_below
);

  always_comb begin
    is_equal = (cnt_val == cmp_val);
    is_below = (cnt_val <  cmp_val);
  end

endmodule

// File: rtl/oc_clear_hold.sv
module oc_clear_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_en,
  input  logic ext_clr,
  input  logic upd_evt,
  output logic clr_act
);

  logic hold_q;
  logic hold_d;
  logic hold_en;
  logic clr_req;

  always_comb begin
    clr_req = clr_en & ext_clr;
    if (clr_req)      hold_d = 1'b1;
    else if (upd_evt) hold_d = 1'b0;
    else              hold_d = hold_q;
    hold_en = (hold_d != hold_q);
    clr_act = clr_req | hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

endmodule

// File: rtl/oc_level_sel.sv
module oc_level_sel
  import oc_chan_pkg::*;
(
  input  logic [OC_MODE_W-1:0] oc_mode,
  input  logic                 is_equal,
  input  logic                 is_below,
  input  logic                 clr_act,
  input  logic                 cur_lvl,
  output logic                 nxt_lvl
);

  oc_mode_e mode;

  always_comb begin
    mode    = oc_mode_e'(oc_mode);
    nxt_lvl = cur_lvl;
    if (clr_act) begin
      nxt_lvl = 1'b0;
    end else begin
      unique case (mode)
        OCM_FREEZE: nxt_lvl = cur_lvl;
        OCM_SET:    nxt_lvl = is_equal ? 1'b1 : cur_lvl;
        OCM_CLR:    nxt_lvl = is_equal ? 1'b0 : cur_lvl;
        OCM_TGL:    nxt_lvl = is_equal ? ~cur_lvl : cur_lvl;
        OCM_LO:     nxt_lvl = 1'b0;
        OCM_HI:     nxt_lvl = 1'b1;
        OCM_PWM_A:  nxt_lvl = is_below;
        OCM_PWM_B:  nxt_lvl = ~is_below;
        default:    nxt_lvl = cur_lvl;
      endcase
    end
  end

endmodule

// File: rtl/oc_ref_channel.sv
module oc_ref_channel
  import oc_chan_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       oc_mode,
  input  logic             clr_en,
  input  logic             ext_clr,
  input  logic             upd_evt,
  output logic             ref_out
);

  logic rst_sync_n;
  logic is_equal;
  logic is_below;
  logic clr_act;
  logic ref_q;
  logic ref_d;
  logic ref_en;

  oc_rst_sync #(.STAGES(RST_STAGE)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  oc_cmp_unit #(.CNT_W(CNT_W)) cmp_i (
    .cnt_val  (cnt_val),
    .cmp_val  (cmp_val),
    .is_equal (is_equal),
    .is_below (is_below)
  );

  oc_clear_hold clr_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_en  (clr_en),
    .ext_clr (ext_clr),
    .upd_evt (upd_evt),
    .clr_act (clr_act)
  );

  oc_level_sel sel_i (
    .oc_mode  (oc_mode),
    .is_equal (is_equal),
    .is_below (is_below),
    .clr_act  (clr_act),
    .cur_lvl  (ref_q),
    .nxt_lvl  (ref_d)
  );

  always_comb begin
    ref_en = (ref_d != ref_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ref_q <= 1'b0;
    else if (ref_en)  ref_q <= ref_d;
  end

  assign ref_out = ref_q;

endmodule

// File: rtl/oc_ref_channel_chk.sv
module oc_ref_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cmp_val,
  input logic [2:0]       oc_mode,
  input logic             clr_en,
  input logic             ext_clr,
  input logic             upd_evt,
  input logic             clr_act,
  input logic             ref_out
);

  // R2
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd0 && !clr_act) |=> $stable(ref_out));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd3 && !clr_act && cnt_val == cmp_val) |=> (ref_out != $past(ref_out)));

  // R6
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd4) |=> !ref_out);

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd5 && !clr_act) |=> ref_out);

  // R7
  pwm_a_below_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd6 && !clr_act && cnt_val < cmp_val) |=> ref_out);

  // R8
  pwm_b_below_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_mode == 3'd7 && !clr_act && cnt_val < cmp_val) |=> !ref_out);

  // R9
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_en && ext_clr) |=> !ref_out);

  // R10
  clear_held_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_en && ext_clr) ##1 (!upd_evt) |=> !ref_out);

endmodule

bind oc_ref_channel oc_ref_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cnt_val    (cnt_val),
  .cmp_val    (cmp_val),
  .oc_mode    (oc_mode),
  .clr_en     (clr_en),
  .ext_clr    (ext_clr),
  .upd_evt    (upd_evt),
  .clr_act    (clr_act),
  .ref_out    (ref_out)
);

// File: tb/oc_ref_channel_tb_top.sv
module oc_ref_channel_tb_top;

  localparam int unsigned CNT_W = 16;

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cmp_val;
  logic [2:0]       oc_mode;
  logic             clr_en;
  logic             ext_clr;
  logic             upd_evt;
  logic             ref_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  oc_ref_channel #(.CNT_W(CNT_W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .cmp_val (cmp_val),
    .oc_mode (oc_mode),
    .clr_en  (clr_en),
    .ext_clr (ext_clr),
    .upd_evt (upd_evt),
    .ref_out (ref_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (ref_out !== exp) begin
      errors++;
      $display("FAIL %s: ref_out=%b expected=%b at %0t", tag, ref_out, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_val = '0; cmp_val = '0; oc_mode = 3'd5;
    clr_en = 1'b0; ext_clr = 1'b0; upd_evt = 1'b0;
    tick(); tick();
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    tick(); tick();
    chk(1'b0, "R1 sync window");
    tick();
    chk(1'b1, "R1 first active edge");
  endtask

  task automatic t_set();
    oc_mode = 3'd4; tick();
    oc_mode = 3'd1; cmp_val = 16'd9; cnt_val = 16'd5; tick();
    chk(1'b0, "R3 no match");
    cnt_val = 16'd9; tick();
    chk(1'b1, "R3 match");
    cnt_val = 16'd10; tick();
    chk(1'b1, "R3 keep");
  endtask

  task automatic t_clear();
    oc_mode = 3'd2; cmp_val = 16'd9; cnt_val = 16'd3; tick();
    chk(1'b1, "R4 no match");
    cnt_val = 16'd9; tick();
    chk(1'b0, "R4 match");
  endtask

  task automatic t_freeze();
    oc_mode = 3'd0; cnt_val = 16'd9; cmp_val = 16'd9; tick();
    chk(1'b0, "R2 frozen low");
    oc_mode = 3'd5; tick();
    oc_mode = 3'd0; tick();
    chk(1'b1, "R2 frozen high match");
    cnt_val = 16'd1; tick();
    chk(1'b1, "R2 frozen high no match");
  endtask

  task automatic t_toggle();
    oc_mode = 3'd4; tick();
    oc_mode = 3'd3; cmp_val = 16'd4; cnt_val = 16'd4; tick();
    chk(1'b1, "R5 toggle 1");
    tick();
    chk(1'b0, "R5 toggle 2");
    tick();
    chk(1'b1, "R5 toggle 3");
    cnt_val = 16'd5; tick();
    chk(1'b1, "R5 hold");
  endtask

  task automatic t_force();
    oc_mode = 3'd4; cnt_val = 16'd7; cmp_val = 16'd7; tick();
    chk(1'b0, "R6 forced low at match");
    oc_mode = 3'd5; cnt_val = 16'd2; tick();
    chk(1'b1, "R6 forced high");
    oc_mode = 3'd4; tick();
    chk(1'b0, "R6 forced low");
  endtask

  task automatic t_pwm(input logic [2:0] m, input logic [CNT_W-1:0] cv, input string tag);
    oc_mode = m; cmp_val = cv;
    for (int i = 0; i < 16; i++) begin
      cnt_val = CNT_W'(i); tick();
      chk((m == 3'd6) ? (cnt_val < cv) : !(cnt_val < cv), {tag, " up"});
    end
    for (int i = 15; i >= 0; i--) begin
      cnt_val = CNT_W'(i); tick();
      chk((m == 3'd6) ? (cnt_val < cv) : !(cnt_val < cv), {tag, " down"});
    end
  endtask

  task automatic t_pwm_edges();
    oc_mode = 3'd6; cmp_val = '0; cnt_val = '0; tick();
    chk(1'b0, "R7 cmp zero");
    cmp_val = '1; cnt_val = '1; tick();
    chk(1'b0, "R7 cmp max at max");
    cnt_val = '1 - 1'b1; tick();
    chk(1'b1, "R7 cmp max below");
    oc_mode = 3'd7; tick();
    chk(1'b0, "R8 cmp max below");
  endtask

  task automatic t_ext_clear();
    oc_mode = 3'd5; cnt_val = 16'd1; cmp_val = 16'd8;
    clr_en = 1'b0; ext_clr = 1'b1; tick();
    chk(1'b1, "R11 clear disabled");
    clr_en = 1'b1; tick();
    chk(1'b0, "R9 clear applied");
    ext_clr = 1'b0; tick();
    chk(1'b0, "R10 held 1");
    clr_en = 1'b0; tick();
    chk(1'b0, "R10 held 2");
    upd_evt = 1'b1; tick();
    chk(1'b0, "R10 update edge");
    upd_evt = 1'b0; tick();
    chk(1'b1, "R10 resumed");
    clr_en = 1'b1; ext_clr = 1'b1; upd_evt = 1'b1; tick();
    chk(1'b0, "R10 clear beats update");
    ext_clr = 1'b0; upd_evt = 1'b0; tick();
    chk(1'b0, "R10 still held");
    upd_evt = 1'b1; tick();
    upd_evt = 1'b0; tick();
    chk(1'b1, "R10 resumed again");
    clr_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_set();
    t_clear();
    t_freeze();
    t_toggle();
    t_force();
    t_pwm(3'd6, 16'd6, "R7");
    t_pwm(3'd7, 16'd6, "R8");
    t_pwm_edges();
    t_ext_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule